// File: doc/BRIEF.md
# Parallel Head-Tail Bundle Decoder

This block unpacks a fixed-size instruction bundle in which every instruction is split into a fixed-width head and a variable-length tail. The heads sit at fixed positions from the front of the bundle. The tails are built from small units and are packed backward from the far end. Each tail length depends only on its own head, so all lengths are found at once. The only serial path is the short adder chain that turns those lengths into tail start offsets.

One bundle is accepted in each cycle that `in_valid` is high. One cycle later the block presents, for every slot, the head, the tail (right-aligned), the tail length in units and the tail offset, together with a per-slot valid flag. A bundle whose heads and tails need more units than the bundle holds is flagged as malformed, and none of its slots is reported valid. The tail-length table is a parameter, so a different opcode assignment needs no change to the logic.

Top module: `hat_bundle_decoder`

## Requirements
- R1: A 128-bit bundle carries the index of its last valid slot in bits [2:0]. The remaining bits are 25 units of 5 bits, with unit u at bits [3+5u +: 5]. Head k is the 10 bits at [3+10k +: 10], and it appears unchanged on `slot_head[10k +: 10]`.
- R2: A slot's tail length comes from the head's low 4 bits (the opcode) through the parameter table. With the default table, the length is (opcode mod 6) + 1, a value from 1 to 6, on `slot_tlen[3k +: 3]`.
- R3: The tail offset of slot 0 is 0. The tail offset of slot k is the sum of the tail lengths of slots 0 to k-1, counted in units from the end of the bundle, on `slot_toff[6k +: 6]`.
- R4: Tail k occupies units 25-off-len up to 24-off. It is output on `slot_tail[30k +: 30]` with its lowest unit in bits [4:0] and zeros above its length.
- R5: `slot_valid[k]` is 1 exactly when k is no greater than the last-slot index and the bundle is not malformed.
- R6: A bundle is malformed when 2*(last+1) plus the sum of the tail lengths of slots 0 to last exceeds 25. Such a bundle raises `out_malformed` and clears every `slot_valid` bit. A bundle that uses exactly 25 units is not malformed.
- R7: The outputs follow an accepted bundle one clock edge later. `out_valid` is high exactly in the cycle after `in_valid` was high. While `in_valid` is low, all slot outputs and `out_malformed` hold their values.
- R8: While reset is held, `out_valid`, `out_malformed` and `slot_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept `in_bundle` this cycle |
| in_bundle | input | 128 | Bundle: last-slot index and 25 units |
| out_valid | output | 1 | Outputs were refreshed by the previous cycle's bundle |
| out_malformed | output | 1 | Latest bundle overflows its 25 units |
| slot_valid | output | 8 | Per-slot instruction present |
| slot_head | output | 80 | Per-slot 10-bit head |
| slot_tlen | output | 24 | Per-slot tail length in units |
| slot_toff | output | 48 | Per-slot tail offset from the bundle end, in units |
| slot_tail | output | 240 | Per-slot tail, right-aligned, zero-filled |

## Verification
The hardest case to reach is the edge of the unit budget: a bundle that fills exactly 25 units must decode, and a bundle one unit larger must be rejected. Random opcodes almost never land on that edge, because the edge depends on the combined sum of every length in the bundle. For each slot count from 4 to 8, the stimulus therefore works out the tail total that reaches 25 units and the total that reaches 26. It then assigns the opcodes greedily so the lengths add up to exactly each total. A broad random sweep across all slot counts covers the table mapping and the tail extraction.

// File: rtl/hat_pkg.sv
package hat_pkg;
  localparam int OPC_W    = 4;
  localparam int OPC_N    = 1 << OPC_W;
  localparam int MAX_TAIL = 6;
  localparam int TLEN_W   = $clog2(MAX_TAIL + 1);
  localparam int LUT_BITS = OPC_N * TLEN_W;

  // Default opcode-to-length map: cycles through 1..MAX_TAIL.
  function automatic logic [LUT_BITS-1:0] default_len_table();
    logic [LUT_BITS-1:0] t;
    t = '0;
    for (int o = 0; o < OPC_N; o++) begin
      t[o*TLEN_W +: TLEN_W] = TLEN_W'((o % MAX_TAIL) + 1);
    end
    return t;
  endfunction
endpackage

// File: rtl/hat_len_lut.sv
module hat_len_lut
  import hat_pkg::*;
#(
  parameter logic [LUT_BITS-1:0] LEN_TABLE = default_len_table()
) (
  input  logic [OPC_W-1:0]  opc,
  output logic [TLEN_W-1:0] tlen
);
  logic [TLEN_W-1:0] raw;

  always_comb begin
    raw = LEN_TABLE[int'(opc)*TLEN_W +: TLEN_W];
    // keep every length in 1..MAX_TAIL whatever the table holds
    if (raw == '0)                         tlen = TLEN_W'(1);
    else if (int'(raw) > MAX_TAIL)         tlen = TLEN_W'(MAX_TAIL);
    else                                   tlen = raw;
  end
endmodule

// File: rtl/hat_tail_extract.sv
module hat_tail_extract
  import hat_pkg::*;
#(
  parameter int UNIT_W    = 5,
  parameter int NUM_UNITS = 25,
  parameter int TOFF_W    = 6,
  localparam int BODY_W   = UNIT_W * NUM_UNITS,
  localparam int TAIL_W   = UNIT_W * MAX_TAIL
) (
  input  logic [BODY_W-1:0] units,
  input  logic [TOFF_W-1:0] toff,
  input  logic [TLEN_W-1:0] tlen,
  output logic [TAIL_W-1:0] tail
);
  always_comb begin
    tail = '0;
    for (int j = 0; j < MAX_TAIL; j++) begin
      int u;
      u = NUM_UNITS - int'(toff) - int'(tlen) + j;
      if (j < int'(tlen) && u >= 0 && u < NUM_UNITS) begin
        tail[j*UNIT_W +: UNIT_W] = units[u*UNIT_W +: UNIT_W];
      end
    end
  end
endmodule

// File: rtl/hat_bundle_decoder.sv
module hat_bundle_decoder
  import hat_pkg::*;
#(
  parameter int UNIT_W    = 5,
  parameter int NUM_UNITS = 25,
  parameter int SLOTS     = 8,
  parameter logic [LUT_BITS-1:0] LEN_TABLE = default_len_table(),
  localparam int CNT_W    = $clog2(SLOTS),
  localparam int HEAD_W   = 2 * UNIT_W,
  localparam int BODY_W   = UNIT_W * NUM_UNITS,
  localparam int BUNDLE_W = CNT_W + BODY_W,
  localparam int TAIL_W   = UNIT_W * MAX_TAIL,
  localparam int TOFF_W   = $clog2(SLOTS * MAX_TAIL + 1),
  localparam int USED_W   = $clog2(2 * SLOTS + SLOTS * MAX_TAIL + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [BUNDLE_W-1:0]        in_bundle,
  output logic                       out_valid,
  output logic                       out_malformed,
  output logic [SLOTS-1:0]           slot_valid,
  output logic [SLOTS*HEAD_W-1:0]    slot_head,
  output logic [SLOTS*TLEN_W-1:0]    slot_tlen,
  output logic [SLOTS*TOFF_W-1:0]    slot_toff,
  output logic [SLOTS*TAIL_W-1:0]    slot_tail
);
  logic [CNT_W-1:0]  last_idx;
  logic [BODY_W-1:0] body;
  logic [HEAD_W-1:0] head_w [SLOTS];
  logic [TLEN_W-1:0] len_w  [SLOTS];
  logic [TOFF_W-1:0] off_w  [SLOTS];
  logic [TAIL_W-1:0] tail_w [SLOTS];
  logic [USED_W-1:0] used_units;
  logic              bad_d;
  logic [SLOTS-1:0]  vld_d;

  assign last_idx = in_bundle[CNT_W-1:0];
  assign body     = in_bundle[BUNDLE_W-1:CNT_W];

  // parallel length decode, then the serial offset chain
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign head_w[k] = body[k*HEAD_W +: HEAD_W];

    hat_len_lut #(.LEN_TABLE(LEN_TABLE)) u_lut (
      .opc  (head_w[k][OPC_W-1:0]),
      .tlen (len_w[k])
    );

    if (k == 0) begin : g_first
      assign off_w[k] = '0;
    end else begin : g_rest
      assign off_w[k] = off_w[k-1] + TOFF_W'(len_w[k-1]);
    end

    hat_tail_extract #(
      .UNIT_W(UNIT_W), .NUM_UNITS(NUM_UNITS), .TOFF_W(TOFF_W)
    ) u_ext (
      .units (body),
      .toff  (off_w[k]),
      .tlen  (len_w[k]),
      .tail  (tail_w[k])
    );
  end

  // unit budget of the whole bundle
  always_comb begin
    used_units = USED_W'(2) * (USED_W'(last_idx) + USED_W'(1))
               + USED_W'(off_w[last_idx]) + USED_W'(len_w[last_idx]);
    bad_d = (int'(used_units) > NUM_UNITS);
    for (int k = 0; k < SLOTS; k++) begin
      vld_d[k] = (k <= int'(last_idx)) && !bad_d;
    end
  end

  // next-state
  logic                    ov_n, bad_n;
  logic [SLOTS-1:0]        vld_n;
  logic [SLOTS*HEAD_W-1:0] head_n, head_q;
  logic [SLOTS*TLEN_W-1:0] len_n,  len_q;
  logic [SLOTS*TOFF_W-1:0] off_n,  off_q;
  logic [SLOTS*TAIL_W-1:0] tail_n, tail_q;
  logic                    ov_q, bad_q;
  logic [SLOTS-1:0]        vld_q;

  always_comb begin
    ov_n  = in_valid;
    bad_n = in_valid ? bad_d : bad_q;
    vld_n = in_valid ? vld_d : vld_q;
    for (int k = 0; k < SLOTS; k++) begin
      head_n[k*HEAD_W +: HEAD_W] = head_w[k];
      len_n [k*TLEN_W +: TLEN_W] = len_w[k];
      off_n [k*TOFF_W +: TOFF_W] = off_w[k];
      tail_n[k*TAIL_W +: TAIL_W] = tail_w[k];
    end
  end

  // control registers, reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q  <= 1'b0;
      bad_q <= 1'b0;
      vld_q <= '0;
    end else begin
      ov_q  <= ov_n;
      bad_q <= bad_n;
      vld_q <= vld_n;
    end
  end

  // datapath registers, load-enabled, no reset
  always_ff @(posedge clk) begin
    if (in_valid) begin
      head_q <= head_n;
      len_q  <= len_n;
      off_q  <= off_n;
      tail_q <= tail_n;
    end
  end

  assign out_valid     = ov_q;
  assign out_malformed = bad_q;
  assign slot_valid    = vld_q;
  assign slot_head     = head_q;
  assign slot_tlen     = len_q;
  assign slot_toff     = off_q;
  assign slot_tail     = tail_q;
endmodule

// File: rtl/hat_bundle_decoder_chk.sv
module hat_bundle_decoder_chk
  import hat_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int TOFF_W = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    out_valid,
  input logic                    out_malformed,
  input logic [SLOTS-1:0]        slot_valid,
  input logic [SLOTS*TLEN_W-1:0] slot_tlen,
  input logic [SLOTS*TOFF_W-1:0] slot_toff
);
  // R6
  bad_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_malformed |-> slot_valid == '0);

  // R5
  valid_contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_valid + SLOTS'(1)) & slot_valid) == '0);

  // R7
  accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(slot_valid) && $stable(out_malformed) && !out_valid);

  // R3
  first_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid[0] |-> slot_toff[TOFF_W-1:0] == '0);

  for (genvar k = 0; k < SLOTS; k++) begin : g_k
    // R2
    tlen_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_valid[k] |-> (slot_tlen[k*TLEN_W +: TLEN_W] != '0 &&
                         int'(slot_tlen[k*TLEN_W +: TLEN_W]) <= MAX_TAIL));
    if (k > 0) begin : g_chain
      // R3
      offset_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid[k] |-> slot_toff[k*TOFF_W +: TOFF_W] ==
          slot_toff[(k-1)*TOFF_W +: TOFF_W] + TOFF_W'(slot_tlen[(k-1)*TLEN_W +: TLEN_W]));
    end
  end
endmodule

bind hat_bundle_decoder hat_bundle_decoder_chk #(.SLOTS(SLOTS), .TOFF_W(TOFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_malformed(out_malformed), .slot_valid(slot_valid),
  .slot_tlen(slot_tlen), .slot_toff(slot_toff)
);

// File: tb/sim_hat_bundle_decoder.sv
module sim_hat_bundle_decoder;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] in_bundle;
  logic         out_valid, out_malformed;
  logic [7:0]   slot_valid;
  logic [79:0]  slot_head;
  logic [23:0]  slot_tlen;
  logic [47:0]  slot_toff;
  logic [239:0] slot_tail;

  hat_bundle_decoder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bundle(in_bundle),
    .out_valid(out_valid), .out_malformed(out_malformed), .slot_valid(slot_valid),
    .slot_head(slot_head), .slot_tlen(slot_tlen), .slot_toff(slot_toff),
    .slot_tail(slot_tail)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1234_5678;

  logic        e_mal;
  logic [7:0]  e_vld;
  logic [9:0]  e_head [8];
  int          e_len  [8];
  int          e_off  [8];
  logic [29:0] e_tail [8];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic model(input logic [127:0] b);
    int last, acc, used, s, u;
    last = int'(b[2:0]);
    acc = 0;
    for (int k = 0; k < 8; k++) begin
      e_head[k] = b[3+10*k +: 10];
      e_len[k]  = (int'(e_head[k][3:0]) % 6) + 1;
      e_off[k]  = acc;
      acc += e_len[k];
      e_tail[k] = '0;
      s = 25 - e_off[k] - e_len[k];
      for (int j = 0; j < e_len[k]; j++) begin
        u = s + j;
        if (u >= 0) e_tail[k][5*j +: 5] = b[3+5*u +: 5];
      end
    end
    used  = 2*(last+1) + e_off[last] + e_len[last];
    e_mal = (used > 25);
    for (int k = 0; k < 8; k++) e_vld[k] = (k <= last) && !e_mal;
  endtask

  task automatic apply(input logic [127:0] b);
    @(negedge clk);
    in_bundle = b;
    in_valid  = 1'b1;
    model(b);
    @(posedge clk);
    #(CLK_PERIOD/4);
    chk(out_valid == 1'b1, "R7", "out_valid", 64'(out_valid), 64'd1);
    chk(out_malformed == e_mal, "R6", "malformed", 64'(out_malformed), 64'(e_mal));
    chk(slot_valid == e_vld, "R5", "slot_valid", 64'(slot_valid), 64'(e_vld));
    for (int k = 0; k < 8; k++) begin
      if (e_vld[k]) begin
        chk(slot_head[10*k +: 10] == e_head[k], "R1", "head",
            64'(slot_head[10*k +: 10]), 64'(e_head[k]));
        chk(int'(slot_tlen[3*k +: 3]) == e_len[k], "R2", "tlen",
            64'(slot_tlen[3*k +: 3]), 64'(e_len[k]));
        chk(int'(slot_toff[6*k +: 6]) == e_off[k], "R3", "toff",
            64'(slot_toff[6*k +: 6]), 64'(e_off[k]));
        chk(slot_tail[30*k +: 30] == e_tail[k], "R4", "tail",
            64'(slot_tail[30*k +: 30]), 64'(e_tail[k]));
      end
    end
    // idle cycle with a different bundle: outputs must hold (R7)
    @(negedge clk);
    in_valid  = 1'b0;
    in_bundle = ~b;
    @(posedge clk);
    #(CLK_PERIOD/4);
    chk(out_valid == 1'b0, "R7", "idle out_valid", 64'(out_valid), 64'd0);
    chk(slot_valid == e_vld && out_malformed == e_mal, "R7", "idle hold valid",
        64'({out_malformed, slot_valid}), 64'({e_mal, e_vld}));
    chk(slot_head[9:0] == e_head[0], "R7", "idle hold head",
        64'(slot_head[9:0]), 64'(e_head[0]));
  endtask

  // n slots whose tail lengths add to exactly total
  task automatic directed(input int n, input int total);
    logic [127:0] b;
    int rem, ln;
    b = {rnd(), rnd(), rnd(), rnd()};
    b[2:0] = 3'(n - 1);
    rem = total;
    for (int k = 0; k < n; k++) begin
      ln = rem - (n - 1 - k);
      if (ln > 6) ln = 6;
      b[3+10*k +: 4] = 4'(ln - 1);
      rem -= ln;
    end
    apply(b);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_bundle = '0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    // R8
    chk(out_valid == 1'b0 && out_malformed == 1'b0 && slot_valid == '0, "R8",
        "reset state", 64'({out_valid, out_malformed, slot_valid}), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // edge of the unit budget: exactly full (R6 fits) and one unit over (R6 rejects)
    for (int n = 4; n <= 8; n++) begin
      directed(n, 25 - 2*n);
      directed(n, 26 - 2*n);
    end
    // smallest and largest tails everywhere (R2, R4)
    directed(8, 8);
    directed(2, 12);
    directed(1, 6);
    directed(1, 1);

    // random sweep over every slot count (R1..R6)
    for (int last = 0; last < 8; last++) begin
      for (int i = 0; i < 40; i++) begin
        logic [127:0] b;
        b = {rnd(), rnd(), rnd(), rnd()};
        b[2:0] = 3'(last);
        apply(b);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule